// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block is the register bank of a power-management companion device. A host reaches it through a simple register port made of a 5-bit register address, a 16-bit write word, separate read and write strobes, and a registered 16-bit read word. The bank holds:

- an interrupt pending/mask pair that drives a level interrupt line;
- an ADC channel selector with a per-channel result table and a sample-control register;
- a calibration word and two common control words;
- a status word that tracks the power key;
- a watchdog location that can request a system shutdown.

Single-cycle event strobes from the rest of the device mark power-key changes and ADC conversion completion. No real conversion, timekeeping or audio function is modelled. The locations that belong to those functions decode as valid but read as zero and ignore writes. Addresses outside the map raise an error pulse.

Top module: `pmic_regbank`

## Requirements
- R1: After reset the pending word is 0x0000, the mask word 0xFFFF, the calibration word 0x0001, the status word 0x0020, both control words, the selected channel and the sample word 0, and `irq`, `rdata`, `shutdown_req` and `addr_err` are all 0. A read of address 0x00 returns 0x0215, with bit 7 also set when `variant_sel` is 1.
- R2: A read of address 0x01 returns the pending word. A write to 0x01 XORs the written word into the pending word. Event strobes in the same cycle OR their bits in after the XOR.
- R3: Address 0x02 is the read/write mask word, where a 1 masks a source. In the cycle after any change to pending or mask, `irq` equals 1 exactly when (pending AND NOT mask) is nonzero.
- R4: A read of address 0x08 returns the selected channel in bits 13:10 and that channel's 10-bit result in bits 9:0. All other bits are 0.
- R5: A write to 0x08 sets the selected channel to bits 13:10 of the written word and sets pending bit 8.
- R6: An `adc_done` strobe sets pending bit 8. It also sets the bit of the sample word (address 0x09) whose index is the channel selected before that clock edge.
- R7: A write to 0x09 clears each sample bit that is 1 in the written word. An `adc_done` strobe in the same cycle is applied after the clear.
- R8: A write of 0x0000 to address 0x17 produces a one-cycle `shutdown_req` pulse in the next cycle, but only when bit 1 of the control word at 0x0D is 1. Any other write there has no effect.
- R9: A `key_evt` strobe sets pending bit 0. It also sets status (address 0x16) bit 5 to 0 when `key_down` is 1, and to 1 when `key_down` is 0.
- R10: Addresses 0x06 (calibration), 0x0D and 0x0E (control words 1 and 2) read back the last word written to them.
- R11: Addresses 0x03-0x05, 0x0A-0x0C, 0x0F-0x11 and 0x18-0x1F read as 0 and ignore writes. Writes to 0x00 and 0x16 change nothing.
- R12: A read or write to 0x07 or 0x12-0x15 pulses `addr_err` for one cycle in the next cycle and changes no state. Such a read returns 0.
- R13: `rdata` is loaded one cycle after a cycle with `rd_en` high and holds its value in every cycle that follows one without a read.
- R14: The default result table holds 0x3C2, 0x0FC, 0x165, 0x07B, 0x3FF, 0x011, 0x011, 0x250 for channels 1-8 and 0x002, 0x011, 0x3D0, 0x330 for channels 10-13. Channels 0, 9, 14 and 15 read a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_sel | input | 1 | Selects the variant identity (sets ID bit 7) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Registered read word |
| addr_err | output | 1 | One-cycle pulse after an access outside the map |
| key_evt | input | 1 | Power-key change strobe |
| key_down | input | 1 | Key level qualifying `key_evt` (1 = pressed) |
| adc_done | input | 1 | ADC conversion-complete strobe |
| irq | output | 1 | Level interrupt, high while an unmasked source is pending |
| shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
All state changes at the edge that samples a strobe. `rdata`, `addr_err` and `shutdown_req` are registered, so they are due in the cycle after the access. `irq` is decoded from the registered pending and mask words, so it also settles in the cycle after a write or an event.

The bench drives every stimulus half a period before an edge and applies the same stimulus to its behavioural model at that edge. It then compares all four outputs at the following falling edge, which is exactly where each result is due. Same-cycle collisions are covered: an event together with a pending-word XOR, and `adc_done` together with a sample clear.

// File: rtl/pmic_pkg.sv
// Package: shared address map, bit positions and reset constants of the
// power-management register bank. Assumes a 16-bit data word.
package pmic_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int NCH_DEF  = 16;
    localparam int RES_DEF  = 10;

    localparam logic [ADDR_W-1:0] AD_IDENT   = 5'h00;
    localparam logic [ADDR_W-1:0] AD_PEND    = 5'h01;
    localparam logic [ADDR_W-1:0] AD_MASK    = 5'h02;
    localparam logic [ADDR_W-1:0] AD_CALIB   = 5'h06;
    localparam logic [ADDR_W-1:0] AD_CONV    = 5'h08;
    localparam logic [ADDR_W-1:0] AD_SAMPLE  = 5'h09;
    localparam logic [ADDR_W-1:0] AD_CTRL_A  = 5'h0D;
    localparam logic [ADDR_W-1:0] AD_CTRL_B  = 5'h0E;
    localparam logic [ADDR_W-1:0] AD_STATE   = 5'h16;
    localparam logic [ADDR_W-1:0] AD_WDOG    = 5'h17;

    localparam logic [DATA_W-1:0] IDENT_BASE = 16'h0215;
    localparam int IDENT_VAR_BIT = 7;
    localparam int PEND_KEY_BIT  = 0;
    localparam int PEND_CONV_BIT = 8;
    localparam int STATE_KEY_BIT = 5;
    localparam int WDOG_ARM_BIT  = 1;
    localparam int CONV_CH_LSB   = 10;

    // Returns 1 for every address that decodes inside the map.
    function automatic logic addr_in_map(input logic [ADDR_W-1:0] a);
        return !((a == 5'h07) || ((a >= 5'h12) && (a <= 5'h15)));
    endfunction

    // Default per-channel results packed channel 0 in the low bits.
    function automatic logic [NCH_DEF*RES_DEF-1:0] default_results();
        logic [NCH_DEF*RES_DEF-1:0] r;
        r = '0;
        r[1*RES_DEF  +: RES_DEF] = 10'h3C2;
        r[2*RES_DEF  +: RES_DEF] = 10'h0FC;
        r[3*RES_DEF  +: RES_DEF] = 10'h165;
        r[4*RES_DEF  +: RES_DEF] = 10'h07B;
        r[5*RES_DEF  +: RES_DEF] = 10'h3FF;
        r[6*RES_DEF  +: RES_DEF] = 10'h011;
        r[7*RES_DEF  +: RES_DEF] = 10'h011;
        r[8*RES_DEF  +: RES_DEF] = 10'h250;
        r[10*RES_DEF +: RES_DEF] = 10'h002;
        r[11*RES_DEF +: RES_DEF] = 10'h011;
        r[12*RES_DEF +: RES_DEF] = 10'h3D0;
        r[13*RES_DEF +: RES_DEF] = 10'h330;
        return r;
    endfunction
endpackage

// File: rtl/pmic_irq.sv
// Interrupt pending/mask pair. Pending is toggled by host writes and then
// OR-ed with event bits; the level output is decoded from the two
// registered words. Assumes one write strobe per word per cycle.
module pmic_irq #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pend,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] pend,
    output logic [DW-1:0] mask,
    output logic          irq
);
    logic [DW-1:0] pend_toggled;

    // Host toggle first, events merged after it.
    always_comb pend_toggled = wr_pend ? (pend ^ wdata) : pend;

    // Pending and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= pend_toggled | set_bits;
            if (wr_mask) mask <= wdata;
        end
    end

    // Level interrupt from the unmasked pending bits.
    always_comb irq = |(pend & ~mask);
endmodule

// File: rtl/pmic_adc.sv
// ADC channel selector, constant per-channel result table and
// sample-control word. A completion strobe marks the channel selected
// before its edge. Assumes $clog2(NUM_CH) bits fit at CH_LSB in DW.
module pmic_adc #(
    parameter int DW      = 16,
    parameter int NUM_CH  = 16,
    parameter int RES_W   = 10,
    parameter int CH_LSB  = 10,
    parameter logic [NUM_CH-1:0] CH_MASK = 16'h3DFE,
    parameter logic [NUM_CH*RES_W-1:0] RESULTS = pmic_pkg::default_results()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_chan,
    input  logic              wr_sample,
    input  logic [DW-1:0]     wdata,
    input  logic              adc_done,
    output logic [DW-1:0]     conv_word,
    output logic [NUM_CH-1:0] sample
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [CH_W-1:0]  chan;
    logic [RES_W-1:0] res_tab [NUM_CH];
    logic [NUM_CH-1:0] sample_cleared;

    // Result table: fitted channels take their parameter value.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_res
        if (CH_MASK[c]) begin : g_fit
            assign res_tab[c] = RESULTS[c*RES_W +: RES_W];
        end else begin : g_empty
            assign res_tab[c] = '0;
        end
    end

    // Host clear of sample bits before the completion mark.
    always_comb sample_cleared = wr_sample ? (sample & ~wdata[NUM_CH-1:0]) : sample;

    // Channel select and sample-control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan   <= '0;
            sample <= '0;
        end else begin
            if (wr_chan) chan <= wdata[CH_LSB +: CH_W];
            sample <= sample_cleared | (adc_done ? (NUM_CH'(1) << chan) : '0);
        end
    end

    // Read word: channel number above the result.
    always_comb begin
        conv_word = '0;
        conv_word[CH_LSB +: CH_W] = chan;
        conv_word[RES_W-1:0]      = res_tab[chan];
    end
endmodule

// File: rtl/pmic_ctrl.sv
// Calibration, two control words, key status and watchdog shutdown.
// The shutdown pulse is registered and lasts one cycle per qualifying write.
module pmic_ctrl #(
    parameter int DW = 16,
    parameter logic [DW-1:0] CAL_RST   = 16'h0001,
    parameter logic [DW-1:0] STATE_RST = 16'h0020,
    parameter int KEY_BIT = 5,
    parameter int ARM_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cal,
    input  logic          wr_ctl_a,
    input  logic          wr_ctl_b,
    input  logic          wr_wdog,
    input  logic [DW-1:0] wdata,
    input  logic          key_evt,
    input  logic          key_down,
    output logic [DW-1:0] cal,
    output logic [DW-1:0] ctl_a,
    output logic [DW-1:0] ctl_b,
    output logic [DW-1:0] state,
    output logic          shutdown_req
);
    // Plain read/write words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal   <= CAL_RST;
            ctl_a <= '0;
            ctl_b <= '0;
        end else begin
            if (wr_cal)   cal   <= wdata;
            if (wr_ctl_a) ctl_a <= wdata;
            if (wr_ctl_b) ctl_b <= wdata;
        end
    end

    // Key status bit follows the latest key event (0 while pressed).
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= STATE_RST;
        else if (key_evt) state[KEY_BIT] <= !key_down;
    end

    // Shutdown pulse on a zero write while the arm bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) shutdown_req <= 1'b0;
        else        shutdown_req <= wr_wdog && (wdata == '0) && ctl_a[ARM_BIT];
    end
endmodule

// File: rtl/pmic_regbank.sv
// Top of the register bank: decodes the 5-bit address, steers write
// strobes to the sub-blocks, registers the read word and flags accesses
// outside the map. Assumes rd_en and wr_en are single-cycle strobes.
module pmic_regbank
    import pmic_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF,
    parameter int RES_W  = RES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              addr_err,
    input  logic              key_evt,
    input  logic              key_down,
    input  logic              adc_done,
    output logic              irq,
    output logic              shutdown_req
);
    logic in_map;
    logic [DATA_W-1:0] pend, mask, conv_word, cal, ctl_a, ctl_b, state;
    logic [NUM_CH-1:0] sample;
    logic [DATA_W-1:0] set_bits, rd_word;

    always_comb in_map = addr_in_map(addr);

    // Event bits for the pending word.
    always_comb begin
        set_bits = '0;
        set_bits[PEND_KEY_BIT]  = key_evt;
        set_bits[PEND_CONV_BIT] = adc_done || (wr_en && addr == AD_CONV);
    end

    pmic_irq #(.DW(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_pend(wr_en && addr == AD_PEND),
        .wr_mask(wr_en && addr == AD_MASK),
        .wdata(wdata), .set_bits(set_bits),
        .pend(pend), .mask(mask), .irq(irq)
    );

    pmic_adc #(.DW(DATA_W), .NUM_CH(NUM_CH), .RES_W(RES_W), .CH_LSB(CONV_CH_LSB)) u_adc (
        .clk(clk), .rst_n(rst_n),
        .wr_chan(wr_en && addr == AD_CONV),
        .wr_sample(wr_en && addr == AD_SAMPLE),
        .wdata(wdata), .adc_done(adc_done),
        .conv_word(conv_word), .sample(sample)
    );

    pmic_ctrl #(.DW(DATA_W), .KEY_BIT(STATE_KEY_BIT), .ARM_BIT(WDOG_ARM_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_cal(wr_en && addr == AD_CALIB),
        .wr_ctl_a(wr_en && addr == AD_CTRL_A),
        .wr_ctl_b(wr_en && addr == AD_CTRL_B),
        .wr_wdog(wr_en && addr == AD_WDOG),
        .wdata(wdata), .key_evt(key_evt), .key_down(key_down),
        .cal(cal), .ctl_a(ctl_a), .ctl_b(ctl_b), .state(state),
        .shutdown_req(shutdown_req)
    );

    // Read multiplexer; unlisted and out-of-map addresses give zero.
    always_comb begin
        rd_word = '0;
        case (addr)
            AD_IDENT:  begin
                rd_word = IDENT_BASE;
                rd_word[IDENT_VAR_BIT] = variant_sel;
            end
            AD_PEND:   rd_word = pend;
            AD_MASK:   rd_word = mask;
            AD_CALIB:  rd_word = cal;
            AD_CONV:   rd_word = conv_word;
            AD_SAMPLE: rd_word = DATA_W'(sample);
            AD_CTRL_A: rd_word = ctl_a;
            AD_CTRL_B: rd_word = ctl_b;
            AD_STATE:  rd_word = state;
            default:   rd_word = '0;
        endcase
    end

    // Registered read word and out-of-map error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            addr_err <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_word;
            addr_err <= (rd_en || wr_en) && !in_map;
        end
    end
endmodule

// File: rtl/pmic_regbank_chk.sv
// Checker for pmic_regbank: temporal properties over ports and the
// pending/mask state, attached to every instance by bind.
module pmic_regbank_chk
    import pmic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              key_evt,
    input logic              adc_done,
    input logic              irq,
    input logic              shutdown_req,
    input logic              addr_err,
    input logic [DATA_W-1:0] pend,
    input logic [DATA_W-1:0] mask
);
    AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq); // R3
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_MASK) |=> (mask == $past(wdata))); // R3
    AST_CONV_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_CONV) |=> pend[PEND_CONV_BIT]); // R5
    AST_DONE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> pend[PEND_CONV_BIT]); // R6
    AST_KEY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt |=> pend[PEND_KEY_BIT]); // R9
    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_en && addr == AD_WDOG && wdata == '0)); // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past((wr_en || rd_en) && !addr_in_map(addr))); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R13
endmodule

bind pmic_regbank pmic_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .key_evt(key_evt), .adc_done(adc_done),
    .irq(irq), .shutdown_req(shutdown_req), .addr_err(addr_err),
    .pend(pend), .mask(mask)
);

// File: tb/pmic_regbank_test.sv
// Bench: behavioural reference model updated at every edge; all outputs
// compared at the following falling edge.
module pmic_regbank_test;
    logic clk = 0, rst_n = 0, variant_sel = 0, wr_en = 0, rd_en = 0;
    logic [4:0] addr = '0;
    logic [15:0] wdata = '0;
    logic key_evt = 0, key_down = 0, adc_done = 0;
    logic [15:0] rdata;
    logic addr_err, irq, shutdown_req;

    int total = 0, bad = 0;
    int m_pend, m_mask, m_cal, m_c1, m_c2, m_state, m_chan, m_sample;
    int e_rdata, e_err, e_sd, e_irq;

    always #2 clk = ~clk;

    pmic_regbank uut (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .addr_err(addr_err), .key_evt(key_evt), .key_down(key_down),
        .adc_done(adc_done), .irq(irq), .shutdown_req(shutdown_req)
    );

    function automatic int result_of(int ch);
        case (ch)
            1: return 'h3C2;  2: return 'h0FC;  3: return 'h165;  4: return 123;
            5: return 1023;   6: return 'h011;  7: return 'h011;  8: return 'h250;
            10: return 2;     11: return 'h011; 12: return 'h3D0; 13: return 'h330;
            default: return 0;
        endcase
    endfunction

    function automatic bit outside(int a);
        return (a == 7) || (a >= 'h12 && a <= 'h15);
    endfunction

    function automatic int model_read(int a);
        case (a)
            'h00: return 'h0215 | (variant_sel ? 'h80 : 0);
            'h01: return m_pend;
            'h02: return m_mask;
            'h06: return m_cal;
            'h08: return (m_chan << 10) | result_of(m_chan);
            'h09: return m_sample;
            'h0D: return m_c1;
            'h0E: return m_c2;
            'h16: return m_state;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic step(bit wr, bit rd, int a, int d, bit kev, bit kdn, bit adn, string tag);
        int old_chan;
        wr_en = wr; rd_en = rd; addr = a[4:0]; wdata = d[15:0];
        key_evt = kev; key_down = kdn; adc_done = adn;
        @(posedge clk);
        if (rd) e_rdata = outside(a) ? 0 : model_read(a);
        e_err = (wr || rd) && outside(a);
        e_sd  = wr && a == 'h17 && d == 0 && m_c1[1];
        old_chan = m_chan;
        if (wr) begin
            case (a)
                'h01: m_pend = m_pend ^ d;
                'h02: m_mask = d;
                'h06: m_cal = d;
                'h08: begin m_chan = (d >> 10) & 15; m_pend = m_pend | 'h100; end
                'h09: m_sample = m_sample & ~d & 'hFFFF;
                'h0D: m_c1 = d;
                'h0E: m_c2 = d;
                default: ;
            endcase
        end
        if (kev) begin m_pend = m_pend | 1; m_state = kdn ? 0 : 'h20; end
        if (adn) begin m_pend = m_pend | 'h100; m_sample = m_sample | (1 << old_chan); end
        e_irq = ((m_pend & ~m_mask & 'hFFFF) != 0);
        @(negedge clk);
        check(tag, "rdata", rdata, e_rdata);
        check(tag, "irq", irq, e_irq);
        check(tag, "shutdown_req", shutdown_req, e_sd);
        check(tag, "addr_err", addr_err, e_err);
    endtask

    task automatic idle(string tag);  step(0, 0, 0, 0, 0, 0, 0, tag); endtask
    task automatic wr(int a, int d, string tag); step(1, 0, a, d, 0, 0, 0, tag); endtask
    task automatic rd(int a, string tag); step(0, 1, a, 0, 0, 0, 0, tag); endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_pend = 0; m_mask = 'hFFFF; m_cal = 1; m_c1 = 0; m_c2 = 0;
        m_state = 'h20; m_chan = 0; m_sample = 0;
        e_rdata = 0; e_err = 0; e_sd = 0; e_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle("R1 reset");
        rd('h00, "R1 ident"); variant_sel = 1; rd('h00, "R1 variant ident");
        rd('h02, "R1 mask reset"); rd('h06, "R1 cal reset"); rd('h16, "R1 status reset");
        // R9: key press and release; masked so no interrupt yet
        step(0, 0, 0, 0, 1, 1, 0, "R9 key press");
        rd('h16, "R9 status pressed"); rd('h01, "R9 pending key");
        wr('h02, 'hFFFE, "R3 unmask key"); rd('h02, "R3 mask readback");
        wr('h01, 'h0001, "R2 xor clear");
        step(0, 0, 0, 0, 1, 0, 0, "R9 key release");
        rd('h16, "R9 status released");
        step(1, 0, 'h01, 'h0001, 1, 0, 0, "R2 xor with event");
        rd('h01, "R2 pending after collision");
        // R13: read word holds without a read
        idle("R13 hold"); idle("R13 hold 2");
        // ADC channel select and result table
        wr('h08, 'h1400, "R5 select ch5"); rd('h01, "R5 pending bit8");
        rd('h08, "R4 ch5 word"); wr('h08, 'h2400, "R5 select ch9");
        rd('h08, "R14 empty ch9"); wr('h08, 'h3400, "R5 select ch13");
        rd('h08, "R14 ch13"); wr('h08, 'h0400, "R5 select ch1"); rd('h08, "R14 ch1");
        wr('h02, 'hFEFF, "R3 unmask conv"); wr('h01, 'h0101, "R2 clear two");
        step(0, 0, 0, 0, 0, 0, 1, "R6 done ch1");
        wr('h08, 'h0800, "R5 select ch2");
        step(0, 0, 0, 0, 0, 0, 1, "R6 done ch2");
        rd('h09, "R6 sample bits");
        step(1, 0, 'h09, 'h0002, 0, 0, 1, "R7 clear with done");
        rd('h09, "R7 sample after collision");
        wr('h09, 'hFFFF, "R7 clear all"); rd('h09, "R7 sample empty");
        // Watchdog arming
        wr('h17, 'h0000, "R8 disarmed zero");
        wr('h0D, 'h0002, "R10 ctl1 arm"); rd('h0D, "R10 ctl1 readback");
        wr('h17, 'h0001, "R8 armed nonzero");
        wr('h17, 'h0000, "R8 armed zero");
        idle("R8 pulse ends");
        // Plain words
        wr('h06, 'hABCD, "R10 cal write"); rd('h06, "R10 cal readback");
        wr('h0E, 'h1234, "R10 ctl2 write"); rd('h0E, "R10 ctl2 readback");
        // Ignored writes
        wr('h03, 'hFFFF, "R11 unimpl write"); rd('h03, "R11 unimpl read");
        wr('h1F, 'h5555, "R11 high unimpl"); rd('h1F, "R11 high unimpl read");
        wr('h00, 'h0000, "R11 ident write"); rd('h00, "R11 ident unchanged");
        wr('h16, 'h0000, "R11 status write"); rd('h16, "R11 status unchanged");
        // Outside the map
        rd('h07, "R12 read 0x07"); wr('h13, 'hFFFF, "R12 write 0x13");
        rd('h15, "R12 read 0x15"); idle("R12 pulse ends");
        wr('h02, 'h0000, "R3 unmask all"); wr('h01, m_pend, "R2 clear all");
        rd('h01, "R2 pending zero");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule